// File: doc/BRIEF.md
# Debug Communication Mailbox Channel

This block is a two-way mailbox between an external debug host and the on-chip CPU. It holds two word-wide registers. The host fills one of them for the CPU to collect. The CPU fills the other for the host to collect. This is also the register that a move-to-debug-register instruction on the CPU writes, so the host can read out CPU register contents one word at a time. Each register has a full flag, set when its producer writes and cleared when its consumer reads. Both ports can read both flags through a status word.

Two host-side events raise a CPU interrupt request: the host reading the CPU-to-host word, and the host writing a new host-to-CPU word. Each event is held in its own sticky pending bit, and the CPU clears these bits by writing ones to them. Together these give software the flow control it needs to run its own debug protocol over the channel. A flash security lock input changes no access rights on either port. Its level can be read in the status word.

Both ports use a simple strobe interface: write enable, read enable, address and data. Read data is registered and appears in the cycle after the read strobe. It holds its value until the next read. Reset is synchronous and active high.

Top module: `dbg_mailbox`

## Requirements
- R1: A host write to address 0 loads the host-to-CPu word and sets its full flag. A CPU read of address 0 returns that word on cpu_rdata in the cycle after the strobe.
- R2: A CPU write to address 0 loads the CPU-to-host word and sets its full flag. A host read of address 0 returns that word on dbg_rdata in the cycle after the strobe.
- R3: Address 1 on either port reads the status word, with bit 0 = CPU-to-host full and bit 1 = host-to-CPU full. A consumer read of a word clears its full flag.
- R4: A write to a word that is full and not read in the same cycle overwrites the data and sets an overrun bit (bit 2 for CPU-to-host, bit 3 for host-to-CPU). The consumer's next read of that word clears the bit.
- R5: A host read of address 0 sets pending bit 0. The pending bits are read at address 2 on either port.
- R6: A host write of address 0 sets pending bit 1.
- R7: A CPU write to address 2 clears each pending bit written as one and leaves bits written as zero unchanged. A new event in the same cycle as its clear leaves the bit set.
- R8: irq is high exactly when a pending bit is set. It changes on the same clock edge as the pending bits.
- R9: sec_lock has no effect on any read or write. Its level is shown in status bit 4.
- R10: When the producer writes a full word in the same cycle that the consumer reads it, the read returns the old word, the full flag stays set and no overrun is recorded.
- R11: Reset clears both words, both full flags, both overrun bits, the pending bits, irq and both read data outputs.
- R12: Address 3 reads as zero on both ports. Host writes to addresses 1 to 3 and CPU writes to addresses 1 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_lock | input | 1 | Flash security lock level (status only) |
| dbg_wr_en | input | 1 | Host write strobe |
| dbg_rd_en | input | 1 | Host read strobe |
| dbg_addr | input | ADDR_W | Host register address |
| dbg_wdata | input | DATA_W | Host write data |
| dbg_rdata | output | DATA_W | Host read data, one cycle after strobe |
| cpu_wr_en | input | 1 | CPU write strobe |
| cpu_rd_en | input | 1 | CPU read strobe |
| cpu_addr | input | ADDR_W | CPU register address |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_rdata | output | DATA_W | CPU read data, one cycle after strobe |
| irq | output | 1 | Interrupt request to the CPU |

## Verification
Two pairs of functions can collide in one cycle. The first is a producer refilling a word while its consumer drains it. The second is the CPU clearing a pending bit while the host raises the same event. The bench drives both ports in the same cycle to create each collision. For the refill case it checks that the read returned the old word and that the status word shows full with no overrun. For the clear case it reads back the pending register and checks that the bit raised again stays set while the other bit is cleared.

// File: rtl/dbg_mbox_pkg.sv
package dbg_mbox_pkg;

  // pending bit positions: CPU decodes these when clearing
  localparam int unsigned MB_NUM_EV  = 2;
  localparam int unsigned EV_HOST_RD = 0;
  localparam int unsigned EV_HOST_WR = 1;

  typedef enum logic [1:0] {
    RG_DATA = 2'd0,
    RG_STAT = 2'd1,
    RG_PEND = 2'd2,
    RG_NONE = 2'd3
  } mb_reg_e;

  // first member is the MSB: lock=4, h2c_ovr=3, c2h_ovr=2, h2c_full=1, c2h_full=0
  typedef struct packed {
    logic lock;
    logic h2c_ovr;
    logic c2h_ovr;
    logic h2c_full;
    logic c2h_full;
  } mb_stat_t;

endpackage

// File: rtl/mbox_slot.sv
module mbox_slot #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic         rd,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q,
  output logic         full,
  output logic         ovr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q    <= '0;
      full <= 1'b0;
      ovr  <= 1'b0;
    end else begin
      if (wr) q <= wdata;
      // a producer write beats a same-cycle consumer read
      if (wr)      full <= 1'b1;
      else if (rd) full <= 1'b0;
      // overwrite of an unconsumed word is an overrun
      if (wr && full && !rd) ovr <= 1'b1;
      else if (rd)           ovr <= 1'b0;
    end
  end

endmodule

// File: rtl/mbox_event.sv
module mbox_event #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] ev,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend,
  output logic         irq
);

  logic [N-1:0] pend_nxt;

  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      // a fresh event outranks a clear in the same cycle
      assign pend_nxt[i] = ev[i] | (pend[i] & ~clr[i]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      irq  <= 1'b0;
    end else begin
      pend <= pend_nxt;
      irq  <= |pend_nxt;
    end
  end

endmodule

// File: rtl/mbox_rdport.sv
module mbox_rdport #(
  parameter int unsigned W  = 32,
  parameter int unsigned SW = 5,
  parameter int unsigned NP = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic          sel_data,
  input  logic          sel_stat,
  input  logic          sel_pend,
  input  logic [W-1:0]  data,
  input  logic [SW-1:0] stat,
  input  logic [NP-1:0] pend,
  output logic [W-1:0]  rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      if (sel_data)      rdata <= data;
      else if (sel_stat) rdata <= W'(stat);
      else if (sel_pend) rdata <= W'(pend);
      else               rdata <= '0;
    end
  end

endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox
  import dbg_mbox_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_lock,
  input  logic              dbg_wr_en,
  input  logic              dbg_rd_en,
  input  logic [ADDR_W-1:0] dbg_addr,
  input  logic [DATA_W-1:0] dbg_wdata,
  output logic [DATA_W-1:0] dbg_rdata,
  input  logic              cpu_wr_en,
  input  logic              cpu_rd_en,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              irq
);

  localparam int unsigned STAT_W = $bits(mb_stat_t);

  // address decode
  logic dbg_data_wr, dbg_data_rd, cpu_data_wr, cpu_data_rd, cpu_pend_wr;
  logic dbg_is_data, dbg_is_stat, dbg_is_pend;
  logic cpu_is_data, cpu_is_stat, cpu_is_pend;

  assign dbg_is_data = (dbg_addr == ADDR_W'(RG_DATA));
  assign dbg_is_stat = (dbg_addr == ADDR_W'(RG_STAT));
  assign dbg_is_pend = (dbg_addr == ADDR_W'(RG_PEND));
  assign cpu_is_data = (cpu_addr == ADDR_W'(RG_DATA));
  assign cpu_is_stat = (cpu_addr == ADDR_W'(RG_STAT));
  assign cpu_is_pend = (cpu_addr == ADDR_W'(RG_PEND));

  assign dbg_data_wr = dbg_wr_en && dbg_is_data;
  assign dbg_data_rd = dbg_rd_en && dbg_is_data;
  assign cpu_data_wr = cpu_wr_en && cpu_is_data;
  assign cpu_data_rd = cpu_rd_en && cpu_is_data;
  assign cpu_pend_wr = cpu_wr_en && cpu_is_pend;

  // CPU-to-host word: CPU produces, host consumes
  logic [DATA_W-1:0] c2h_q;
  logic              c2h_full, c2h_ovr;

  mbox_slot #(.W(DATA_W)) u_c2h (
    .clk   (clk),
    .rst   (rst),
    .wr    (cpu_data_wr),
    .rd    (dbg_data_rd),
    .wdata (cpu_wdata),
    .q     (c2h_q),
    .full  (c2h_full),
    .ovr   (c2h_ovr)
  );

  // host-to-CPU word: host produces, CPU consumes
  logic [DATA_W-1:0] h2c_q;
  logic              h2c_full, h2c_ovr;

  mbox_slot #(.W(DATA_W)) u_h2c (
    .clk   (clk),
    .rst   (rst),
    .wr    (dbg_data_wr),
    .rd    (cpu_data_rd),
    .wdata (dbg_wdata),
    .q     (h2c_q),
    .full  (h2c_full),
    .ovr   (h2c_ovr)
  );

  // host-side access events feed the sticky pending bits
  logic [MB_NUM_EV-1:0] ev, clr, pend;

  always_comb begin
    ev             = '0;
    ev[EV_HOST_RD] = dbg_data_rd;
    ev[EV_HOST_WR] = dbg_data_wr;
    clr            = cpu_pend_wr ? cpu_wdata[MB_NUM_EV-1:0] : '0;
  end

  mbox_event #(.N(MB_NUM_EV)) u_evt (
    .clk  (clk),
    .rst  (rst),
    .ev   (ev),
    .clr  (clr),
    .pend (pend),
    .irq  (irq)
  );

  // shared status view; the lock level is reported, never enforced
  mb_stat_t stat;

  always_comb begin
    stat.lock     = sec_lock;
    stat.h2c_ovr  = h2c_ovr;
    stat.c2h_ovr  = c2h_ovr;
    stat.h2c_full = h2c_full;
    stat.c2h_full = c2h_full;
  end

  mbox_rdport #(.W(DATA_W), .SW(STAT_W), .NP(MB_NUM_EV)) u_dbg_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (dbg_rd_en),
    .sel_data (dbg_is_data),
    .sel_stat (dbg_is_stat),
    .sel_pend (dbg_is_pend),
    .data     (c2h_q),
    .stat     (stat),
    .pend     (pend),
    .rdata    (dbg_rdata)
  );

  mbox_rdport #(.W(DATA_W), .SW(STAT_W), .NP(MB_NUM_EV)) u_cpu_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (cpu_rd_en),
    .sel_data (cpu_is_data),
    .sel_stat (cpu_is_stat),
    .sel_pend (cpu_is_pend),
    .data     (h2c_q),
    .stat     (stat),
    .pend     (pend),
    .rdata    (cpu_rdata)
  );

endmodule

// File: rtl/dbg_mailbox_chk.sv
module dbg_mailbox_chk
  import dbg_mbox_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic                 irq,
  input logic [MB_NUM_EV-1:0] pend,
  input logic                 h2c_full,
  input logic                 c2h_full,
  input logic                 dbg_data_wr,
  input logic                 dbg_data_rd,
  input logic                 cpu_data_wr,
  input logic                 cpu_data_rd
);

  // R1
  h2c_fill_chk: assert property (@(posedge clk) disable iff (rst)
    dbg_data_wr |=> h2c_full);

  // R2
  c2h_fill_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_data_wr |=> c2h_full);

  // R3
  h2c_drain_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_data_rd && !dbg_data_wr) |=> !h2c_full);

  // R3
  c2h_drain_chk: assert property (@(posedge clk) disable iff (rst)
    (dbg_data_rd && !cpu_data_wr) |=> !c2h_full);

  // R5
  host_rd_event_chk: assert property (@(posedge clk) disable iff (rst)
    dbg_data_rd |=> pend[EV_HOST_RD]);

  // R6
  host_wr_event_chk: assert property (@(posedge clk) disable iff (rst)
    dbg_data_wr |=> pend[EV_HOST_WR]);

  // R8
  irq_follows_pend_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (|pend));

  // R11
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!irq && pend == '0 && !h2c_full && !c2h_full));

endmodule

bind dbg_mailbox dbg_mailbox_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .irq         (irq),
  .pend        (pend),
  .h2c_full    (h2c_full),
  .c2h_full    (c2h_full),
  .dbg_data_wr (dbg_data_wr),
  .dbg_data_rd (dbg_data_rd),
  .cpu_data_wr (cpu_data_wr),
  .cpu_data_rd (cpu_data_rd)
);

// File: tb/dbg_mailbox_tb.sv
module dbg_mailbox_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sec_lock = 1'b0;
  logic        dbg_wr_en = 1'b0, dbg_rd_en = 1'b0;
  logic [1:0]  dbg_addr = '0;
  logic [31:0] dbg_wdata = '0;
  logic [31:0] dbg_rdata;
  logic        cpu_wr_en = 1'b0, cpu_rd_en = 1'b0;
  logic [1:0]  cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        irq;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  dbg_mailbox u_dut (
    .clk(clk), .rst(rst), .sec_lock(sec_lock),
    .dbg_wr_en(dbg_wr_en), .dbg_rd_en(dbg_rd_en), .dbg_addr(dbg_addr),
    .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
    .cpu_wr_en(cpu_wr_en), .cpu_rd_en(cpu_rd_en), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq(irq)
  );

  // scoreboard queues, one per read port
  logic [31:0] exp_d_q[$];
  string       tag_d_q[$];
  logic [31:0] exp_c_q[$];
  string       tag_c_q[$];

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  // monitor: a read strobe seen at an edge is judged at the following negedge
  logic mon_d = 1'b0, mon_c = 1'b0;
  always @(posedge clk) begin
    mon_d <= dbg_rd_en;
    mon_c <= cpu_rd_en;
  end

  always @(negedge clk) begin
    if (mon_d) begin
      if (exp_d_q.size() == 0) chk(dbg_rdata, 32'hxxxx_xxxx, "scoreboard host queue empty");
      else chk(dbg_rdata, exp_d_q.pop_front(), tag_d_q.pop_front());
    end
    if (mon_c) begin
      if (exp_c_q.size() == 0) chk(cpu_rdata, 32'hxxxx_xxxx, "scoreboard cpu queue empty");
      else chk(cpu_rdata, exp_c_q.pop_front(), tag_c_q.pop_front());
    end
  end

  // driver: one cycle on both ports, expectations pushed for reads
  task automatic step(input logic dw, input logic dr, input logic [1:0] da, input logic [31:0] dd,
                      input logic cw, input logic cr, input logic [1:0] ca, input logic [31:0] cd,
                      input logic [31:0] exd, input logic [31:0] exc, input string tag);
    dbg_wr_en = dw; dbg_rd_en = dr; dbg_addr = da; dbg_wdata = dd;
    cpu_wr_en = cw; cpu_rd_en = cr; cpu_addr = ca; cpu_wdata = cd;
    if (dr) begin exp_d_q.push_back(exd); tag_d_q.push_back({tag, " host rd"}); end
    if (cr) begin exp_c_q.push_back(exc); tag_c_q.push_back({tag, " cpu rd"}); end
    @(negedge clk);
    dbg_wr_en = 1'b0; dbg_rd_en = 1'b0; dbg_addr = '0; dbg_wdata = '0;
    cpu_wr_en = 1'b0; cpu_rd_en = 1'b0; cpu_addr = '0; cpu_wdata = '0;
  endtask

  task automatic dwr(input logic [1:0] a, input logic [31:0] v, input string t);
    step(1'b1, 1'b0, a, v, 1'b0, 1'b0, 2'd0, 32'd0, 32'd0, 32'd0, t);
  endtask
  task automatic drd(input logic [1:0] a, input logic [31:0] e, input string t);
    step(1'b0, 1'b1, a, 32'd0, 1'b0, 1'b0, 2'd0, 32'd0, e, 32'd0, t);
  endtask
  task automatic cwr(input logic [1:0] a, input logic [31:0] v, input string t);
    step(1'b0, 1'b0, 2'd0, 32'd0, 1'b1, 1'b0, a, v, 32'd0, 32'd0, t);
  endtask
  task automatic crd(input logic [1:0] a, input logic [31:0] e, input string t);
    step(1'b0, 1'b0, 2'd0, 32'd0, 1'b0, 1'b1, a, 32'd0, 32'd0, e, t);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R11: reset state
    chk({31'd0, irq}, 32'd0, "R11 irq after reset");
    drd(2'd1, 32'h0, "R11 status");
    crd(2'd2, 32'h0, "R11 pending");
    crd(2'd0, 32'h0, "R11 cpu data");

    // R2 / R3: CPU to host
    cwr(2'd0, 32'hA5A5_0001, "R2 write");
    drd(2'd1, 32'h1, "R3 host sees c2h full");
    crd(2'd1, 32'h1, "R3 cpu sees c2h full");
    drd(2'd0, 32'hA5A5_0001, "R2 host collects");
    chk({31'd0, irq}, 32'd1, "R8 irq on host read");
    crd(2'd2, 32'h1, "R5 read event pending");
    drd(2'd1, 32'h0, "R3 c2h drained");

    // R7: clear
    cwr(2'd2, 32'h1, "R7 clear read event");
    chk({31'd0, irq}, 32'd0, "R8 irq drops");
    crd(2'd2, 32'h0, "R7 pending cleared");

    // R1 / R6
    dwr(2'd0, 32'h1234_5678, "R1 host write");
    chk({31'd0, irq}, 32'd1, "R8 irq on host write");
    crd(2'd2, 32'h2, "R6 write event pending");
    crd(2'd1, 32'h2, "R3 h2c full");
    crd(2'd0, 32'h1234_5678, "R1 cpu collects");
    crd(2'd1, 32'h0, "R3 h2c drained");
    cwr(2'd2, 32'h0, "R7 zero write");
    crd(2'd2, 32'h2, "R7 zero bits keep pending");
    cwr(2'd2, 32'h2, "R7 clear write event");

    // R4: overrun both ways
    dwr(2'd0, 32'h1, "R4 first");
    dwr(2'd0, 32'h2, "R4 second");
    crd(2'd1, 32'hA, "R4 h2c overrun");
    crd(2'd0, 32'h2, "R4 newest kept");
    crd(2'd1, 32'h0, "R4 h2c overrun cleared");
    cwr(2'd0, 32'h3, "R4 cpu first");
    cwr(2'd0, 32'h4, "R4 cpu second");
    drd(2'd1, 32'h5, "R4 c2h overrun");
    drd(2'd0, 32'h4, "R4 cpu newest kept");
    drd(2'd1, 32'h0, "R4 c2h overrun cleared");
    cwr(2'd2, 32'h3, "R7 clear all");

    // R10: refill while draining
    cwr(2'd0, 32'h11, "R10 fill");
    step(1'b0, 1'b1, 2'd0, 32'd0, 1'b1, 1'b0, 2'd0, 32'h22, 32'h11, 32'd0, "R10 old word");
    drd(2'd1, 32'h1, "R10 full no overrun");
    drd(2'd0, 32'h22, "R10 new word");
    drd(2'd1, 32'h0, "R10 drained");

    // R7: clear racing a new event
    drd(2'd0, 32'h22, "R7 set read event");
    step(1'b1, 1'b0, 2'd0, 32'h77, 1'b1, 1'b0, 2'd2, 32'h3, 32'd0, 32'd0, "R7 race");
    crd(2'd2, 32'h2, "R7 event beats clear");
    crd(2'd0, 32'h77, "R7 word delivered");
    cwr(2'd2, 32'h3, "R7 clear all");

    // R9: lock changes nothing
    sec_lock = 1'b1;
    drd(2'd1, 32'h10, "R9 lock in status");
    dwr(2'd0, 32'h99, "R9 host write locked");
    crd(2'd0, 32'h99, "R9 cpu read locked");
    cwr(2'd0, 32'h55, "R9 cpu write locked");
    drd(2'd0, 32'h55, "R9 host read locked");
    crd(2'd1, 32'h10, "R9 cpu status locked");
    crd(2'd2, 32'h3, "R9 events while locked");
    sec_lock = 1'b0;
    cwr(2'd2, 32'h3, "R7 clear all");

    // R12: unmapped and read-only addresses
    drd(2'd3, 32'h0, "R12 host addr 3");
    crd(2'd3, 32'h0, "R12 cpu addr 3");
    dwr(2'd1, 32'hFFFF_FFFF, "R12 host write status");
    dwr(2'd2, 32'hFFFF_FFFF, "R12 host write pending");
    dwr(2'd3, 32'hFFFF_FFFF, "R12 host write addr 3");
    cwr(2'd1, 32'hFFFF_FFFF, "R12 cpu write status");
    cwr(2'd3, 32'hFFFF_FFFF, "R12 cpu write addr 3");
    crd(2'd1, 32'h0, "R12 status untouched");
    crd(2'd2, 32'h0, "R12 pending untouched");
    chk({31'd0, irq}, 32'd0, "R12 irq untouched");

    // R11: reset mid-run
    cwr(2'd0, 32'hDEAD, "R11 fill");
    dwr(2'd0, 32'hBEEF, "R11 fill host");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk({31'd0, irq}, 32'd0, "R11 irq cleared");
    chk(cpu_rdata, 32'd0, "R11 cpu rdata cleared");
    crd(2'd1, 32'h0, "R11 flags cleared");
    crd(2'd0, 32'h0, "R11 h2c word cleared");
    drd(2'd0, 32'h0, "R11 c2h word cleared");

    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule